// File: doc/BRIEF.md
# Segmented Paged Address Translator

The translator converts a virtual address into a physical address by walking address-translation tables held in memory. A virtual address has three fields: a segment number, a page number and a word offset. The caller supplies the virtual address, a walk mode and the base address of the top-level table. The block then reads one table entry per level through a single-read memory port. It adds the current field to the pointer found at each level. At the last level it joins the frame number with the offset.

There are three walk shapes. Page-only mode reads one page-table entry. Segment mode reads a segment-table entry and then a page-table entry. Directory mode splits the segment number into two halves and adds a directory read before the segment-table read. Every entry carries a residency flag. An entry whose flag is clear stops the walk and reports which level was missing.

Both data interfaces use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The memory read request holds its address stable until `mem_req_ready` is seen. The read data comes back on `mem_rsp_valid` and cannot be back-pressured. The result is held on `out_valid` until `out_ready` takes it. Holding `out_ready` low stalls the block indefinitely.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address is {s, p, w}. s is the top SEG_W bits, p is the next PAGE_W bits, and w is the low OFF_W bits. The request mode encoding is 0 = page-only, 1 = segment+page, 2 = directory, and 3 behaves exactly like 1.
- R2: In segment+page mode the block reads base+s and then ptr+p, where ptr is the pointer from the first entry. This is exactly two reads, and the result is {frame, w}.
- R3: In directory mode s is split into s1 (its upper SEG_W-SEG_W/2 bits) and s2 (its low SEG_W/2 bits). The reads are base+s1, ptr+s2 and ptr+p, which is exactly three reads.
- R4: In page-only mode the block makes exactly one read, at base+p, and the result is {frame, w}.
- R5: A table entry is MADDR_W+1 bits wide. Bit MADDR_W is the residency flag and bits MADDR_W-1:0 are the pointer. Table addresses are pointer+index, taken modulo 2^MADDR_W.
- R6: An entry read with a clear residency flag ends the walk with no further reads. The result then has out_pa = 0 and a fault code: 1 for a directory-level fault, 2 for a segment-level fault, 3 for a page-level fault. 0 means no fault.
- R7: out_fault keeps its value after the result is taken and is cleared only when the next request is accepted.
- R8: At most one memory read is outstanding. While mem_req_valid is high and mem_req_ready is low, both mem_req_valid and mem_addr stay unchanged.
- R9: req_ready is high only while the block is idle. After a request is accepted, req_ready stays low until the result is taken.
- R10: While out_valid is high and out_ready is low, out_valid, out_pa and out_fault stay unchanged.
- R11: The frame is the low FRAME_W bits of the page-table entry pointer and fills out_pa[PA_W-1:OFF_W]. w fills the low OFF_W bits unchanged, with no carry into the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request may be taken |
| req_vaddr | input | SEG_W+PAGE_W+OFF_W | Virtual address {s, p, w} |
| req_mode | input | 2 | Walk mode (0 page-only, 1 segment+page, 2 directory, 3 as 1) |
| req_base | input | MADDR_W | Base address of the top-level table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | MADDR_W | Table-entry address to read |
| mem_rsp_valid | input | 1 | Read data valid (single cycle) |
| mem_rsp_data | input | MADDR_W+1 | Entry: {resident, pointer} |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_pa | output | FRAME_W+OFF_W | Physical address, or 0 on a fault |
| out_fault | output | 2 | Fault level (0 none, 1 directory, 2 segment, 3 page) |

## Verification
Several properties are checked on every cycle:
- the single-read rule and the stability of the memory request under back-pressure;
- the hold of the result while it is stalled;
- the persistence of the fault code until a new request is taken;
- the number of reads a successful walk makes in each mode.

Other behaviour only shows up in the bench's scenarios. These cover the actual table addresses and pointer chaining, the concatenation of frame and offset with all-ones fields, and address wrap at the top of memory. They also include faults injected at each level, and mode 3 aliasing mode 1. These results are compared against a walk model written independently in the bench.

// File: rtl/spx_pkg.sv
package spx_pkg;
  // Walk level kinds; the numeric values double as the fault codes.
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_DIR  = 2'd1,
    LVL_SEG  = 2'd2,
    LVL_PAGE = 2'd3
  } lvl_kind_t;

  typedef enum logic [1:0] {
    WM_PAGE = 2'd0,
    WM_SEG  = 2'd1,
    WM_DIR  = 2'd2,
    WM_ALT  = 2'd3
  } walk_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_t;
endpackage

// File: rtl/spx_level_map.sv
module spx_level_map
  import spx_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] level,
  output lvl_kind_t  kind,
  output logic       last
);
  always_comb begin
    kind = LVL_PAGE;
    last = 1'b1;
    case (walk_mode_t'(mode))
      WM_PAGE: begin
        kind = LVL_PAGE;
        last = 1'b1;
      end
      WM_DIR: begin
        case (level)
          2'd0:    begin kind = LVL_DIR;  last = 1'b0; end
          2'd1:    begin kind = LVL_SEG;  last = 1'b0; end
          default: begin kind = LVL_PAGE; last = 1'b1; end
        endcase
      end
      default: begin
        if (level == 2'd0) begin
          kind = LVL_SEG;
          last = 1'b0;
        end else begin
          kind = LVL_PAGE;
          last = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/spx_index_sel.sv
module spx_index_sel
  import spx_pkg::*;
#(
  parameter int SEG_W   = 6,
  parameter int PAGE_W  = 5,
  parameter int OFF_W   = 8,
  parameter int MADDR_W = 16
) (
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] vaddr,
  input  logic [1:0]                    mode,
  input  lvl_kind_t                     kind,
  output logic [MADDR_W-1:0]            idx
);
  localparam int VA_W = SEG_W + PAGE_W + OFF_W;
  localparam int S2_W = SEG_W / 2;
  localparam int S1_W = SEG_W - S2_W;

  logic [SEG_W-1:0]  seg_f;
  logic [PAGE_W-1:0] page_f;
  logic [S1_W-1:0]   s1_f;
  logic [S2_W-1:0]   s2_f;

  assign seg_f  = vaddr[VA_W-1 -: SEG_W];
  assign page_f = vaddr[OFF_W +: PAGE_W];
  assign s1_f   = seg_f[SEG_W-1 -: S1_W];
  assign s2_f   = seg_f[S2_W-1:0];

  always_comb begin
    case (kind)
      LVL_DIR:  idx = MADDR_W'(s1_f);
      LVL_SEG:  idx = (walk_mode_t'(mode) == WM_DIR) ? MADDR_W'(s2_f) : MADDR_W'(seg_f);
      default:  idx = MADDR_W'(page_f);
    endcase
  end
endmodule

// File: rtl/spx_walk_ctrl.sv
module spx_walk_ctrl
  import spx_pkg::*;
#(
  parameter int SEG_W   = 6,
  parameter int PAGE_W  = 5,
  parameter int OFF_W   = 8,
  parameter int MADDR_W = 16,
  parameter int FRAME_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]                    req_mode,
  input  logic [MADDR_W-1:0]            req_base,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [MADDR_W-1:0]            mem_addr,
  input  logic                          mem_rsp_valid,
  input  logic [MADDR_W:0]              mem_rsp_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [FRAME_W+OFF_W-1:0]      out_pa,
  output logic [1:0]                    out_fault,
  output logic [SEG_W+PAGE_W+OFF_W-1:0] va_q,
  output logic [1:0]                    mode_q,
  output logic [1:0]                    level_q,
  input  lvl_kind_t                     kind,
  input  logic                          last,
  input  logic [MADDR_W-1:0]            idx
);
  localparam int PA_W = FRAME_W + OFF_W;

  walk_state_t             state_q;
  logic [MADDR_W-1:0]      ptr_q;
  logic [PA_W-1:0]         pa_q;
  logic [1:0]              flt_q;
  logic                    resident;
  logic                    accept;

  assign resident      = mem_rsp_data[MADDR_W];
  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_addr      = ptr_q + idx;
  assign out_valid     = (state_q == ST_DONE);
  assign out_pa        = pa_q;
  assign out_fault     = flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      mode_q  <= '0;
      ptr_q   <= '0;
      level_q <= '0;
      pa_q    <= '0;
      flt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          mode_q  <= req_mode;
          ptr_q   <= req_base;
          level_q <= '0;
          flt_q   <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!resident) begin
            flt_q   <= kind;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else if (last) begin
            pa_q    <= {mem_rsp_data[FRAME_W-1:0], va_q[OFF_W-1:0]};
            state_q <= ST_DONE;
          end else begin
            ptr_q   <= mem_rsp_data[MADDR_W-1:0];
            level_q <= level_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: if (out_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: once a request is taken, no second one is accepted
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R10: stalled result does not change
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pa) && $stable(out_fault));
  // R8: stalled memory request does not change
  a_r8_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));
  // R7: fault code persists until the next accepted request
  a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fault != 2'd0) && !accept |=> out_fault == $past(out_fault));
  // R6: a faulting result carries a zero address
  a_r6_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_fault != 2'd0) |-> out_pa == '0);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int SEG_W   = 6,
  parameter int PAGE_W  = 5,
  parameter int OFF_W   = 8,
  parameter int MADDR_W = 16,
  parameter int FRAME_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]                    req_mode,
  input  logic [MADDR_W-1:0]            req_base,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [MADDR_W-1:0]            mem_addr,
  input  logic                          mem_rsp_valid,
  input  logic [MADDR_W:0]              mem_rsp_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [FRAME_W+OFF_W-1:0]      out_pa,
  output logic [1:0]                    out_fault
);
  localparam int VA_W = SEG_W + PAGE_W + OFF_W;

  logic [VA_W-1:0]    va_q;
  logic [1:0]         mode_q;
  logic [1:0]         level_q;
  lvl_kind_t          kind;
  logic               last;
  logic [MADDR_W-1:0] idx;

  spx_level_map u_map (
    .mode (mode_q),
    .level(level_q),
    .kind (kind),
    .last (last)
  );

  spx_index_sel #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .MADDR_W(MADDR_W)
  ) u_idx (
    .vaddr(va_q),
    .mode (mode_q),
    .kind (kind),
    .idx  (idx)
  );

  spx_walk_ctrl #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .MADDR_W(MADDR_W), .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_mode     (req_mode),
    .req_base     (req_base),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_addr     (mem_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_pa       (out_pa),
    .out_fault    (out_fault),
    .va_q         (va_q),
    .mode_q       (mode_q),
    .level_q      (level_q),
    .kind         (kind),
    .last         (last),
    .idx          (idx)
  );

  // Checker state: reads in flight and reads made by the current walk.
  logic [1:0] inflight_q;
  logic [2:0] refs_q;
  logic [2:0] refs_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q <= '0;
      refs_q     <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_rsp_valid) inflight_q <= inflight_q + 2'd1;
      else if (mem_rsp_valid && !(mem_req_valid && mem_req_ready) && inflight_q != 2'd0)
        inflight_q <= inflight_q - 2'd1;
      if (req_valid && req_ready) refs_q <= '0;
      else if (mem_req_valid && mem_req_ready) refs_q <= refs_q + 3'd1;
    end
  end

  always_comb begin
    case (walk_mode_t'(mode_q))
      WM_PAGE: refs_exp = 3'd1;
      WM_DIR:  refs_exp = 3'd3;
      default: refs_exp = 3'd2;
    endcase
  end

  // R8: never more than one read in flight
  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= 2'd1);
  a_r8_no_issue_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> inflight_q == 2'd0);
  // R2, R3, R4: a clean walk makes exactly the reads its mode calls for
  a_r3_walk_refs: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_fault == 2'd0) |-> refs_q == refs_exp);
endmodule

// File: tb/seg_page_xlate_tb.sv
module seg_page_xlate_tb;
  localparam int SEG_W   = 6;
  localparam int PAGE_W  = 5;
  localparam int OFF_W   = 8;
  localparam int MADDR_W = 16;
  localparam int FRAME_W = 12;
  localparam int VA_W    = SEG_W + PAGE_W + OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int S2_W    = SEG_W / 2;
  localparam int S1_W    = SEG_W - S2_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_mode = '0;
  logic [MADDR_W-1:0] req_base = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [MADDR_W-1:0] mem_addr;
  logic mem_rsp_valid = 1'b0;
  logic [MADDR_W:0] mem_rsp_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [PA_W-1:0] out_pa;
  logic [1:0] out_fault;

  int checks = 0;
  int errors = 0;
  int reads  = 0;

  always #5 clk = ~clk;

  seg_page_xlate #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .MADDR_W(MADDR_W), .FRAME_W(FRAME_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pa(out_pa), .out_fault(out_fault)
  );

  // Memory image: explicit entries override a hashed background.
  logic [MADDR_W:0] ovr [int];

  function automatic logic [MADDR_W:0] memval(input logic [MADDR_W-1:0] a);
    logic [31:0] h;
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    h = {16'h0, a} * 32'h9E37_79B1;
    return {(h[31:29] != 3'd0), h[15:0] ^ h[31:16]};
  endfunction

  function automatic void exp_walk(input logic [VA_W-1:0] va, input logic [1:0] md,
                                   input logic [MADDR_W-1:0] base,
                                   output logic [PA_W-1:0] pa, output logic [1:0] flt,
                                   output int refs);
    logic [SEG_W-1:0] s;
    logic [MADDR_W-1:0] ix [3];
    logic [1:0] kd [3];
    int n;
    logic [MADDR_W-1:0] ptr;
    logic [MADDR_W:0] e;
    s = va[VA_W-1 -: SEG_W];
    if (md == 2'd0) begin
      n = 1; ix[0] = MADDR_W'(va[OFF_W +: PAGE_W]); kd[0] = 2'd3;
    end else if (md == 2'd2) begin
      n = 3;
      ix[0] = MADDR_W'(s[SEG_W-1 -: S1_W]); kd[0] = 2'd1;
      ix[1] = MADDR_W'(s[S2_W-1:0]);        kd[1] = 2'd2;
      ix[2] = MADDR_W'(va[OFF_W +: PAGE_W]); kd[2] = 2'd3;
    end else begin
      n = 2;
      ix[0] = MADDR_W'(s); kd[0] = 2'd2;
      ix[1] = MADDR_W'(va[OFF_W +: PAGE_W]); kd[1] = 2'd3;
    end
    ptr = base; refs = 0; pa = '0; flt = 2'd0;
    for (int i = 0; i < n; i++) begin
      e = memval(ptr + ix[i]);
      refs++;
      if (!e[MADDR_W]) begin
        flt = kd[i]; pa = '0; return;
      end
      if (i == n - 1) pa = {e[FRAME_W-1:0], va[OFF_W-1:0]};
      else ptr = e[MADDR_W-1:0];
    end
  endfunction

  // Memory model: random accept, 0..2 cycles of latency, single-cycle data.
  logic pend = 1'b0;
  logic [MADDR_W-1:0] paddr = '0;
  int dly = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; pend <= 1'b0;
    end else begin
      mem_req_ready <= ($urandom % 4) != 0;
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= memval(paddr); pend <= 1'b0;
        end else dly <= dly - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; paddr <= mem_addr; dly <= int'($urandom % 3); reads <= reads + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [VA_W-1:0] va, input logic [1:0] md,
                       input logic [MADDR_W-1:0] base, input string req);
    logic [PA_W-1:0] epa; logic [1:0] eflt; int erefs; int r0;
    exp_walk(va, md, base, epa, eflt, erefs);
    @(negedge clk);
    req_vaddr = va; req_mode = md; req_base = base; req_valid = 1'b1;
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy", 32'(req_ready), 0);
    while (!out_valid) @(negedge clk);
    chk(out_pa == epa, {req, " pa"}, 32'(out_pa), 32'(epa));
    chk(out_fault == eflt, {req, " fault R6"}, 32'(out_fault), 32'(eflt));
    chk(reads - r0 == erefs, {req, " reads"}, 32'(reads - r0), 32'(erefs));
    repeat ($urandom % 3) @(negedge clk);
    chk(out_valid && out_pa == epa, "R10 hold", 32'(out_pa), 32'(epa));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && req_ready, "R9 idle", 32'(out_valid), 0);
    chk(out_fault == eflt, "R7 fault held", 32'(out_fault), 32'(eflt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !out_valid && !mem_req_valid && out_fault == 2'd0, "reset",
        {28'h0, req_ready, out_valid, mem_req_valid, 1'b0}, 32'h8);
    rst_n = 1'b1;

    // R2 / R11: two-level walk, all-ones offset, pointer bits above the frame dropped
    ovr[16'h1005] = {1'b1, 16'h2000};
    ovr[16'h2003] = {1'b1, 16'hF7FF};
    xlate({6'd5, 5'd3, 8'hFF}, 2'd1, 16'h1000, "R2");
    chk(out_pa == 20'h7FFFF, "R11 concat", 32'(out_pa), 32'h7FFFF);
    // R1: mode 3 aliases mode 1
    xlate({6'd5, 5'd3, 8'h12}, 2'd3, 16'h1000, "R1 alt");
    chk(out_pa == 20'h7FF12, "R1 alt pa", 32'(out_pa), 32'h7FF12);
    // R6: segment fault, then page fault
    ovr[16'h1006] = {1'b0, 16'h3000};
    xlate({6'd6, 5'd0, 8'h00}, 2'd1, 16'h1000, "R6 seg");
    chk(out_fault == 2'd2, "R6 seg code", 32'(out_fault), 2);
    ovr[16'h1007] = {1'b1, 16'h4000};
    ovr[16'h4009] = {1'b0, 16'h0ABC};
    xlate({6'd7, 5'd9, 8'h01}, 2'd1, 16'h1000, "R6 page");
    chk(out_fault == 2'd3, "R6 page code", 32'(out_fault), 3);
    // R7: new request clears the held fault
    ovr[16'h5001] = {1'b1, 16'h0123};
    xlate({6'd0, 5'd1, 8'h44}, 2'd0, 16'h5000, "R4");
    chk(out_pa == 20'h12344 && out_fault == 2'd0, "R4/R7 clear", 32'(out_pa), 32'h12344);
    // R3: directory walk with s1=2, s2=3
    ovr[16'h6002] = {1'b1, 16'h7000};
    ovr[16'h7003] = {1'b1, 16'h8000};
    ovr[16'h8004] = {1'b1, 16'h0FFF};
    xlate({3'd2, 3'd3, 5'd4, 8'hFF}, 2'd2, 16'h6000, "R3");
    chk(out_pa == 20'hFFFFF, "R3 pa", 32'(out_pa), 32'hFFFFF);
    ovr[16'h6005] = {1'b0, 16'h0000};
    xlate({3'd5, 3'd0, 5'd0, 8'h00}, 2'd2, 16'h6000, "R6 dir");
    chk(out_fault == 2'd1, "R6 dir code", 32'(out_fault), 1);
    // R5: table address wraps at the top of memory
    ovr[16'h0001] = {1'b1, 16'h0321};
    xlate({6'd0, 5'd2, 8'h0F}, 2'd0, 16'hFFFF, "R5 wrap");
    chk(out_pa == 20'h3210F, "R5 wrap pa", 32'(out_pa), 32'h3210F);

    // Random walks against the hashed background (R1-R8)
    for (int i = 0; i < 300; i++)
      xlate(VA_W'($urandom), 2'($urandom), MADDR_W'($urandom), "R1 rand");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule